// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of one line in a writeback cache. The cache invalidates other copies on a write and snoops a shared bus. Processor reads and writes arrive on a request channel. Replacement evictions arrive on a second channel. Both channels use valid/ready. A requester holds valid, and the operation's attributes, steady until ready is seen high in the same cycle. Ready may stay low for any number of cycles. Possible causes are a snooped transaction in that cycle or a bus grant that has not yet arrived. When both channels are valid, the processor request is served first and the eviction waits.

When a request cannot finish locally, the controller raises a bus request together with a command. It holds both until the arbiter grants it. The granted cycle is the cycle in which the transaction appears on the bus and the waiting requester is released. Transactions from other caches are presented on the snoop inputs. In the same cycle the controller answers them with a wired shared indication and a flush strobe, which tells the data side to drive the line. An external priority network picks one supplier among several clean sharers and tells this cache through a supplier-enable input. Tag matching, data storage and the arbiter are outside this block.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset the line state output reads Invalid. The state encoding is Invalid 00, Shared 01, Exclusive 10, Modified 11.
- R2: A processor read in Invalid raises a bus request with command read (01). In the granted cycle the request is released. The line becomes Exclusive if shared_in is low in that cycle and Shared if it is high.
- R3: A processor write in Exclusive completes in the cycle it is presented. It raises no bus request and moves the line to Modified.
- R4: A processor write in Shared or Invalid raises a bus request with command read-exclusive (10). In the granted cycle the request is released and the line becomes Modified.
- R5: Reads in Modified, Exclusive or Shared, and writes in Modified, complete in the cycle they are presented, with no bus request and no change of state.
- R6: A snooped read (01) in Modified or Exclusive asserts flush_out and shared_out and moves the line to Shared. A snooped read-exclusive (10) in those states asserts flush_out and moves the line to Invalid.
- R7: In Shared, a snooped read or read-exclusive asserts flush_out only while supplier_en is high. A read also asserts shared_out and leaves the line Shared. A read-exclusive moves it to Invalid. In Invalid, snoops produce neither flush_out nor shared_out.
- R8: An eviction of a Modified line raises a bus request with command writeback (11). In the granted cycle it asserts flush_out, releases the eviction and moves the line to Invalid. An eviction in any other state completes at once with no bus request and leaves the line Invalid.
- R9: A snoop takes priority in its cycle. Neither channel is released and a bus grant is not taken. The waiting request then completes according to the state the snoop left behind.
- R10: The command of a pending request follows the current state. A write in Shared that loses the line to a snooped read-exclusive before its grant still completes with read-exclusive and ends Modified. A pending eviction of a Modified line that a snooped read turns into Shared completes without a writeback.
- R11: While both channels are valid, the processor request is served and evict_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_ready | output | 1 | Processor request completes this cycle |
| evict_valid | input | 1 | Replacement of this line requested |
| evict_ready | output | 1 | Eviction completes this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant; the transaction is on the bus this cycle |
| bus_cmd | output | 2 | Command: 01 read, 10 read-exclusive, 11 writeback |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| supplier_en | input | 1 | This cache is the chosen supplier among sharers |
| shared_in | input | 1 | Wired shared line, sampled on an own read |
| shared_out | output | 1 | Drive of the wired shared line |
| flush_out | output | 1 | Drive line data onto the bus this cycle |
| line_state | output | 2 | Current coherence state |

## Verification
Two functions can fall in the same cycle. A processor request or eviction, whether a local hit or waiting on a grant, can meet a snooped transaction for the same line. The bench provokes this in several cases: a read hit in Modified against a snooped read, a write in Exclusive against a read-exclusive, a pending Shared write against a read-exclusive, and a pending Modified eviction against a read. In each collision cycle it expects the snoop response and no release of either channel. In the cycles that follow, the surviving request must finish as the post-snoop state dictates.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  localparam int ST_W  = 2;
  localparam int CMD_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [CMD_W-1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
(
  input  line_st_t st,
  input  logic     snp_valid,
  input  bus_cmd_t snp_cmd,
  input  logic     supplier_en,
  output logic     shared_out,
  output logic     snp_flush,
  output logic     snp_upd,
  output line_st_t snp_next
);
  // an owner-like copy (M or E) always supplies; a sharer only when chosen
  logic may_supply;
  assign may_supply = (st != ST_S) || supplier_en;

  always_comb begin
    shared_out = 1'b0;
    snp_flush  = 1'b0;
    snp_upd    = 1'b0;
    snp_next   = st;
    if (snp_valid && (st != ST_I)) begin
      case (snp_cmd)
        BC_RD: begin
          shared_out = 1'b1;
          snp_flush  = may_supply;
          snp_upd    = 1'b1;
          snp_next   = ST_S;
        end
        BC_RDX: begin
          snp_flush  = may_supply;
          snp_upd    = 1'b1;
          snp_next   = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_req_unit.sv
module mesi_req_unit
  import mesi_pkg::*;
(
  input  line_st_t st,
  input  logic     cpu_valid,
  input  logic     cpu_write,
  input  logic     evict_valid,
  input  logic     bus_gnt,
  input  logic     snp_valid,
  input  logic     shared_in,
  output logic     cpu_ready,
  output logic     evict_ready,
  output logic     bus_req,
  output bus_cmd_t bus_cmd,
  output logic     wb_flush,
  output logic     req_upd,
  output line_st_t req_next
);
  logic cpu_hit;
  logic own_slot;   // bus cycle usable by this cache: granted and not a snoop

  assign cpu_hit  = cpu_write ? ((st == ST_M) || (st == ST_E)) : (st != ST_I);
  assign own_slot = bus_gnt && !snp_valid;

  always_comb begin
    cpu_ready   = 1'b0;
    evict_ready = 1'b0;
    bus_req     = 1'b0;
    bus_cmd     = BC_NONE;
    wb_flush    = 1'b0;
    req_upd     = 1'b0;
    req_next    = st;
    if (cpu_valid) begin
      if (cpu_hit) begin
        cpu_ready = !snp_valid;
        req_next  = cpu_write ? ST_M : st;
      end else begin
        // command recomputed every cycle from the live state
        bus_req   = 1'b1;
        bus_cmd   = cpu_write ? BC_RDX : BC_RD;
        cpu_ready = own_slot;
        req_next  = cpu_write ? ST_M : (shared_in ? ST_S : ST_E);
      end
      req_upd = cpu_ready;
    end else if (evict_valid) begin
      if (st == ST_M) begin
        bus_req     = 1'b1;
        bus_cmd     = BC_WB;
        evict_ready = own_slot;
        wb_flush    = own_slot;
      end else begin
        evict_ready = !snp_valid;
      end
      req_upd  = evict_ready;
      req_next = ST_I;
    end
  end
endmodule

// File: rtl/mesi_line_state.sv
module mesi_line_state
  import mesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_upd,
  input  line_st_t snp_next,
  input  logic     req_upd,
  input  line_st_t req_next,
  output line_st_t st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= ST_I;
    else if (snp_upd) st_q <= snp_next;
    else if (req_upd) st_q <= req_next;
  end

  // R1: the first sampled edge after reset sees Invalid
  a_r1_reset_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (st_q == ST_I));

  // R9: snoop side and request side never update in the same cycle
  a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_upd && req_upd));
endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
  import mesi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  input  logic             cpu_req_write,
  output logic             cpu_req_ready,
  input  logic             evict_valid,
  output logic             evict_ready,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [CMD_W-1:0] bus_cmd,
  input  logic             snoop_valid,
  input  logic [CMD_W-1:0] snoop_cmd,
  input  logic             supplier_en,
  input  logic             shared_in,
  output logic             shared_out,
  output logic             flush_out,
  output logic [ST_W-1:0]  line_state
);
  line_st_t st, snp_next, req_next;
  bus_cmd_t req_cmd;
  logic     snp_upd, req_upd, snp_flush, wb_flush;

  mesi_snoop_resp u_snoop (
    .st          (st),
    .snp_valid   (snoop_valid),
    .snp_cmd     (bus_cmd_t'(snoop_cmd)),
    .supplier_en (supplier_en),
    .shared_out  (shared_out),
    .snp_flush   (snp_flush),
    .snp_upd     (snp_upd),
    .snp_next    (snp_next)
  );

  mesi_req_unit u_req (
    .st          (st),
    .cpu_valid   (cpu_req_valid),
    .cpu_write   (cpu_req_write),
    .evict_valid (evict_valid),
    .bus_gnt     (bus_gnt),
    .snp_valid   (snoop_valid),
    .shared_in   (shared_in),
    .cpu_ready   (cpu_req_ready),
    .evict_ready (evict_ready),
    .bus_req     (bus_req),
    .bus_cmd     (req_cmd),
    .wb_flush    (wb_flush),
    .req_upd     (req_upd),
    .req_next    (req_next)
  );

  mesi_line_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .snp_upd  (snp_upd),
    .snp_next (snp_next),
    .req_upd  (req_upd),
    .req_next (req_next),
    .st_q     (st)
  );

  assign bus_cmd    = req_cmd;
  assign flush_out  = snp_flush | wb_flush;
  assign line_state = st;

  // R2: a granted read fill lands in E or S according to the shared line
  a_r2_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !cpu_req_write && cpu_req_ready && st == ST_I)
    |=> (st == ($past(shared_in) ? ST_S : ST_E)));

  // R3: a write in Exclusive finishes locally
  a_r3_excl_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_write && st == ST_E && !snoop_valid)
    |-> (cpu_req_ready && !bus_req));

  // R4: every completed write leaves the line Modified
  a_r4_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_write && cpu_req_ready) |=> (st == ST_M));

  // R6: a snooped read-exclusive always invalidates
  a_r6_rdx_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd == BC_RDX) |=> (st == ST_I));

  // R7: an Invalid line never answers a snoop
  a_r7_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && st == ST_I) |-> (!flush_out && !shared_out));

  // R8: writeback is requested only for a Modified line
  a_r8_wb_from_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_WB) |-> (st == ST_M));

  // R9: nothing is released in a snoop cycle
  a_r9_snoop_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> (!cpu_req_ready && !evict_ready));

  // R11: the processor channel wins over eviction
  a_r11_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && evict_valid) |-> !evict_ready);
endmodule

// File: tb/sim_mesi_line_ctl.sv
module sim_mesi_line_ctl;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n;
  logic cpu_req_valid, cpu_req_write, cpu_req_ready;
  logic evict_valid, evict_ready;
  logic bus_req, bus_gnt;
  logic [1:0] bus_cmd;
  logic snoop_valid;
  logic [1:0] snoop_cmd;
  logic supplier_en, shared_in, shared_out, flush_out;
  logic [1:0] line_state;

  mesi_line_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_ready(cpu_req_ready),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .supplier_en(supplier_en),
    .shared_in(shared_in), .shared_out(shared_out), .flush_out(flush_out),
    .line_state(line_state)
  );

  typedef struct {
    string      tag;
    logic       cr, er, br;
    logic [1:0] bc;
    logic       fl, sh;
    logic [1:0] st;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // state codes: I=0 S=1 E=2 M=3; commands: RD=1 RDX=2 WB=3
  task automatic v(input string tag,
                   input logic cv, input logic cw, input logic ev, input logic g,
                   input logic sv, input logic [1:0] sc, input logic su, input logic si,
                   input logic cr, input logic er, input logic br, input logic [1:0] bc,
                   input logic fl, input logic sh, input logic [1:0] st);
    exp_t e;
    @(negedge clk);
    cpu_req_valid = cv; cpu_req_write = cw; evict_valid = ev; bus_gnt = g;
    snoop_valid = sv; snoop_cmd = sc; supplier_en = su; shared_in = si;
    e.tag = tag; e.cr = cr; e.er = er; e.br = br; e.bc = bc;
    e.fl = fl; e.sh = sh; e.st = st;
    q.push_back(e);
  endtask

  // monitor: compares each pushed vector late in the low phase
  initial forever begin
    @(negedge clk);
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      // a bus_cmd expectation only matters while a request is raised
      if ({cpu_req_ready, evict_ready, bus_req, flush_out, shared_out, line_state} !==
          {e.cr, e.er, e.br, e.fl, e.sh, e.st} || (e.br && bus_cmd !== e.bc)) begin
        n_bad++;
        $display("FAIL %s: got rdy=%b evr=%b req=%b cmd=%0d fl=%b sh=%b st=%0d exp rdy=%b evr=%b req=%b cmd=%0d fl=%b sh=%b st=%0d",
                 e.tag, cpu_req_ready, evict_ready, bus_req, bus_cmd, flush_out, shared_out, line_state,
                 e.cr, e.er, e.br, e.bc, e.fl, e.sh, e.st);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_req_valid = 0; cpu_req_write = 0; evict_valid = 0; bus_gnt = 0;
    snoop_valid = 0; snoop_cmd = 0; supplier_en = 0; shared_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //  tag                         cv cw ev g  sv sc su si   cr er br bc fl sh st
    v("R1 reset state",             0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 0, 0, 0, 0);
    v("R2 read miss waits",         1, 0, 0, 0, 0, 0, 0, 0,   0, 0, 1, 1, 0, 0, 0);
    v("R2 read grant unshared",     1, 0, 0, 1, 0, 0, 0, 0,   1, 0, 1, 1, 0, 0, 0);
    v("R5 read hit E",              1, 0, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, 0, 0, 2);
    v("R6 snoop read in E",         0, 0, 0, 0, 1, 1, 0, 0,   0, 0, 0, 0, 1, 1, 2);
    v("R5 read hit S",              1, 0, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, 0, 0, 1);
    v("R7 snoop read S not chosen", 0, 0, 0, 0, 1, 1, 0, 0,   0, 0, 0, 0, 0, 1, 1);
    v("R7 snoop read S chosen",     0, 0, 0, 0, 1, 1, 1, 0,   0, 0, 0, 0, 1, 1, 1);
    v("R4 write in S waits",        1, 1, 0, 0, 0, 0, 0, 0,   0, 0, 1, 2, 0, 0, 1);
    v("R10 pending write snooped",  1, 1, 0, 0, 1, 2, 0, 0,   0, 0, 1, 2, 0, 0, 1);
    v("R10 write grant after inv",  1, 1, 0, 1, 0, 0, 0, 0,   1, 0, 1, 2, 0, 0, 0);
    v("R5 write hit M",             1, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, 0, 0, 3);
    v("R9 read hit vs snoop read",  1, 0, 0, 1, 1, 1, 0, 0,   0, 0, 0, 0, 1, 1, 3);
    v("R9 read after snoop",        1, 0, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, 0, 0, 1);
    v("R4 write S granted",         1, 1, 0, 1, 0, 0, 0, 0,   1, 0, 1, 2, 0, 0, 1);
    v("R6 snoop rdx in M",          0, 0, 0, 0, 1, 2, 0, 0,   0, 0, 0, 0, 1, 0, 3);
    v("R7 snoop read in I",         0, 0, 0, 0, 1, 1, 1, 0,   0, 0, 0, 0, 0, 0, 0);
    v("R2 read grant shared",       1, 0, 0, 1, 0, 0, 0, 1,   1, 0, 1, 1, 0, 0, 0);
    v("R7 snoop rdx S chosen",      0, 0, 0, 0, 1, 2, 1, 0,   0, 0, 0, 0, 1, 0, 1);
    v("R4 write miss I granted",    1, 1, 0, 1, 0, 0, 0, 0,   1, 0, 1, 2, 0, 0, 0);
    v("R8 evict M waits",           0, 0, 1, 0, 0, 0, 0, 0,   0, 0, 1, 3, 0, 0, 3);
    v("R8 evict M granted",         0, 0, 1, 1, 0, 0, 0, 0,   0, 1, 1, 3, 1, 0, 3);
    v("R8 evict in I",              0, 0, 1, 0, 0, 0, 0, 0,   0, 1, 0, 0, 0, 0, 0);
    v("R2 read grant to E",         1, 0, 0, 1, 0, 0, 0, 0,   1, 0, 1, 1, 0, 0, 0);
    v("R3 write in E silent",       1, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, 0, 0, 0, 2);
    v("R11 cpu before evict",       1, 0, 1, 0, 0, 0, 0, 0,   1, 0, 0, 0, 0, 0, 3);
    v("R10 evict M vs snoop read",  0, 0, 1, 1, 1, 1, 0, 0,   0, 0, 1, 3, 1, 1, 3);
    v("R10 evict after downgrade",  0, 0, 1, 0, 0, 0, 0, 0,   0, 1, 0, 0, 0, 0, 1);
    v("R2 read grant to E again",   1, 0, 0, 1, 0, 0, 0, 0,   1, 0, 1, 1, 0, 0, 0);
    v("R6 snoop rdx in E",          0, 0, 0, 0, 1, 2, 0, 0,   0, 0, 0, 0, 1, 0, 2);
    v("R2 read grant third",        1, 0, 0, 1, 0, 0, 0, 0,   1, 0, 1, 1, 0, 0, 0);
    v("R9 E write vs snoop rdx",    1, 1, 0, 0, 1, 2, 0, 0,   0, 0, 0, 0, 1, 0, 2);
    v("R9 write now misses",        1, 1, 0, 0, 0, 0, 0, 0,   0, 0, 1, 2, 0, 0, 0);
    v("R4 write miss granted",      1, 1, 0, 1, 0, 0, 0, 0,   1, 0, 1, 2, 0, 0, 0);
    v("R4 ends modified",           0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 0, 0, 0, 3);
    @(negedge clk);
    cpu_req_valid = 0; cpu_req_write = 0; evict_valid = 0; bus_gnt = 0;
    snoop_valid = 0; snoop_cmd = 0; supplier_en = 0; shared_in = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule